// File: doc/BRIEF.md
# Serial NAND Program and Erase Sequencer

This block runs complete block-erase and page-program operations on a serial NAND device. It drives a single-lane SPI bus in mode 0 and controls chip select. A host gives one request on a simple port: an erase takes a block number, and a program takes a row, a column and a byte count. The block then sends the whole command series itself. It reads the device status until the busy bit clears, or until a bounded number of reads have been made. It ends by raising exactly one of three one-cycle flags: done, fail or timeout.

Every operation starts with a write-enable command. For a program, the data bytes are pulled from the host one at a time. A pulse on `dat_pop` marks each byte consumed, and the host then presents the next byte. Status reads are spaced by a cycle counter whose length is a parameter. Erase failures and program failures are reported from separate status bits. After a failure or a timeout, the block sends a write-disable command before it reports.

Top module: `snand_pe_seq`

## Requirements
- R1: Every accepted request first sends a chip-select frame holding only the byte 0x06.
- R2: An erase then sends one frame of four bytes: 0xD8 followed by the 24-bit row, most significant byte first. The row equals the block number shifted left by 6.
- R3: A program sends a load frame made of 0x84, the column as 16 bits with the high byte first, then exactly `req_len` host bytes in stream order. `dat_pop` pulses once per byte.
- R4: After the load frame, a program sends a commit frame: 0x10 followed by the 24-bit row (`req_row`), most significant byte first.
- R5: Completion is polled with three-byte frames: 0x0F, 0xC0, then one dummy byte during which the status byte is shifted in. Chip select stays high for at least `POLL_CYC` cycles between two consecutive status frames.
- R6: When a status byte has bit 0 clear, the operation has finished. An erase fails if bit 2 is set, and a program fails if bit 3 is set. The bit belonging to the other operation has no effect.
- R7: If bit 0 is still set in the `MAX_POLLS`-th status byte, the block reports a timeout. Exactly `MAX_POLLS` status frames have then been sent.
- R8: On a fail or a timeout, a final frame holding only 0x04 is sent before the flag is raised. A successful operation sends no such frame.
- R9: `busy` rises in the cycle after a request is accepted and falls in the same cycle as a flag. The flags `done`, `fail` and `timeout` are single-cycle pulses, and at most one of them is high at a time.
- R10: A request presented while `busy` is high is ignored. It sends no frame and does not change the running operation.
- R11: The bus runs in SPI mode 0. `spi_sclk` is low whenever `spi_cs_n` is high, and `spi_cs_n` stays high for at least 2*`CLK_DIV` cycles between frames.
- R12: After reset, `spi_cs_n` is 1, while `spi_sclk`, `busy`, `done`, `fail`, `timeout` and `dat_pop` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken only while idle |
| req_prog | input | 1 | 1 = page program, 0 = block erase |
| req_block | input | BLK_W | Block number for an erase |
| req_row | input | ROW_W | Row (page address) for a program |
| req_col | input | COL_W | Column (start byte) for a program |
| req_len | input | LEN_W | Number of data bytes for a program |
| dat_byte | input | 8 | Current program data byte from the host |
| dat_pop | output | 1 | Pulse: `dat_byte` consumed, present the next one |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Pulse: operation completed without error |
| fail | output | 1 | Pulse: device reported erase or program failure |
| timeout | output | 1 | Pulse: status still busy after the retry limit |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data to the device |
| spi_miso | input | 1 | Serial data from the device |

## Verification
Properties checked on every cycle:
- `busy` and the flags hold their relation, and at most one flag is high at a time.
- The serial clock stays idle while chip select is high, and the chip-select gap is never shorter than one bus clock period.
- A timeout comes only after the full count of status reads.
- `dat_pop` fires only inside a frame.

Only the bench scenarios can show that frames carry the right bytes in the right order. They also show:
- which status bit counts as a failure for each operation;
- that write disable appears only on the failure paths;
- that a request made during an operation leaves the frame sequence unchanged.

The bench checks these against a device model that decodes each frame and returns scripted status bytes.

// File: rtl/snand_pe_pkg.sv
package snand_pe_pkg;
  localparam logic [7:0] OP_WREN     = 8'h06;
  localparam logic [7:0] OP_WRDI     = 8'h04;
  localparam logic [7:0] OP_ERASE    = 8'hD8;
  localparam logic [7:0] OP_LOAD     = 8'h84;
  localparam logic [7:0] OP_EXEC     = 8'h10;
  localparam logic [7:0] OP_GETF     = 8'h0F;
  localparam logic [7:0] FEAT_STATUS = 8'hC0;
  localparam int ST_BUSY  = 0;
  localparam int ST_EFAIL = 2;
  localparam int ST_PFAIL = 3;
  localparam logic [7:0] STAT_MASK = 8'h0D;

  typedef enum logic [2:0] {
    S_IDLE, S_WREN, S_LOAD, S_EXEC, S_POLL, S_WAIT, S_WRDI
  } seq_st_e;
endpackage

// File: rtl/snand_spi_byte.sv
module snand_spi_byte #(
  parameter int CLK_DIV = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [7:0] tx,
  input  logic       miso,
  output logic       done,
  output logic [7:0] rx,
  output logic       sclk,
  output logic       mosi
);
  localparam int DW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

  logic          active;
  logic [7:0]    sh;
  logic [2:0]    bits;
  logic [DW-1:0] dcnt;

  assign mosi = sh[7];

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      sh     <= '0;
      bits   <= '0;
      dcnt   <= '0;
      sclk   <= 1'b0;
      done   <= 1'b0;
      rx     <= '0;
    end else begin
      done <= 1'b0;
      if (!active) begin
        if (start) begin
          active <= 1'b1;
          sh     <= tx;
          bits   <= '0;
          dcnt   <= '0;
          sclk   <= 1'b0;
        end
      end else if (dcnt == DW'(CLK_DIV - 1)) begin
        dcnt <= '0;
        if (!sclk) begin
          sclk <= 1'b1;
          rx   <= {rx[6:0], miso};
        end else begin
          sclk <= 1'b0;
          if (bits == 3'd7) begin
            active <= 1'b0;
            done   <= 1'b1;
          end else begin
            bits <= bits + 3'd1;
            sh   <= {sh[6:0], 1'b0};
          end
        end
      end else begin
        dcnt <= dcnt + DW'(1);
      end
    end
  end
endmodule

// File: rtl/snand_frame.sv
module snand_frame #(
  parameter int CLK_DIV = 2,
  parameter int LEN_W   = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [31:0]      hdr,
  input  logic [2:0]       hdr_n,
  input  logic [LEN_W-1:0] tail_n,
  input  logic             tail_rd,
  input  logic [7:0]       dat_byte,
  output logic             dat_pop,
  output logic             done,
  output logic [7:0]       rx_byte,
  output logic             cs_n,
  output logic             sclk,
  output logic             mosi,
  input  logic             miso
);
  localparam int GAP = 2 * CLK_DIV;
  localparam int GW  = (GAP > 1) ? $clog2(GAP) : 1;

  typedef enum logic [1:0] {F_IDLE, F_SHIFT, F_GAP} frm_st_e;

  frm_st_e          st;
  logic [31:0]      hsh;
  logic [2:0]       hcnt;
  logic [LEN_W-1:0] tcnt;
  logic             rd_q;
  logic             go;
  logic [GW-1:0]    gcnt;
  logic             b_start, b_done;
  logic [7:0]       b_tx, b_rx;

  snand_spi_byte #(.CLK_DIV(CLK_DIV)) u_byte (
    .clk(clk), .rst(rst), .start(b_start), .tx(b_tx), .miso(miso),
    .done(b_done), .rx(b_rx), .sclk(sclk), .mosi(mosi)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= F_IDLE;
      hsh     <= '0;
      hcnt    <= '0;
      tcnt    <= '0;
      rd_q    <= 1'b0;
      go      <= 1'b0;
      gcnt    <= '0;
      b_start <= 1'b0;
      b_tx    <= '0;
      dat_pop <= 1'b0;
      done    <= 1'b0;
      rx_byte <= '0;
      cs_n    <= 1'b1;
    end else begin
      b_start <= 1'b0;
      dat_pop <= 1'b0;
      done    <= 1'b0;
      case (st)
        F_IDLE: if (start) begin
          hsh  <= hdr;
          hcnt <= hdr_n;
          tcnt <= tail_n;
          rd_q <= tail_rd;
          cs_n <= 1'b0;
          go   <= 1'b1;
          st   <= F_SHIFT;
        end
        F_SHIFT: begin
          if (go) begin
            go      <= 1'b0;
            b_start <= 1'b1;
            if (hcnt != 3'd0) begin
              b_tx <= hsh[31:24];
              hsh  <= {hsh[23:0], 8'h00};
              hcnt <= hcnt - 3'd1;
            end else begin
              b_tx    <= rd_q ? 8'h00 : dat_byte;
              dat_pop <= !rd_q;
              tcnt    <= tcnt - LEN_W'(1);
            end
          end else if (b_done) begin
            if (hcnt != 3'd0 || tcnt != '0) begin
              go <= 1'b1;
            end else begin
              rx_byte <= b_rx;
              cs_n    <= 1'b1;
              gcnt    <= '0;
              st      <= F_GAP;
            end
          end
        end
        F_GAP: begin
          if (gcnt == GW'(GAP - 1)) begin
            done <= 1'b1;
            st   <= F_IDLE;
          end else begin
            gcnt <= gcnt + GW'(1);
          end
        end
        default: st <= F_IDLE;
      endcase
    end
  end

  // R3
  dat_pop_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
    dat_pop |-> !cs_n);
endmodule

// File: rtl/snand_poll_timer.sv
module snand_poll_timer #(
  parameter int POLL_CYC = 12500
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic expire
);
  localparam int TW = (POLL_CYC > 1) ? $clog2(POLL_CYC) : 1;

  logic          run;
  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      run    <= 1'b0;
      cnt    <= '0;
      expire <= 1'b0;
    end else begin
      expire <= 1'b0;
      if (start) begin
        run <= 1'b1;
        cnt <= '0;
      end else if (run) begin
        if (cnt == TW'(POLL_CYC - 1)) begin
          run    <= 1'b0;
          expire <= 1'b1;
        end else begin
          cnt <= cnt + TW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/snand_pe_seq.sv
module snand_pe_seq
  import snand_pe_pkg::*;
#(
  parameter int CLK_DIV       = 2,
  parameter int POLL_CYC      = 12500,
  parameter int MAX_POLLS     = 200,
  parameter int PAGES_PER_BLK = 64,
  parameter int BLK_W         = 10,
  parameter int ROW_W         = 16,
  parameter int COL_W         = 12,
  parameter int LEN_W         = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             req_prog,
  input  logic [BLK_W-1:0] req_block,
  input  logic [ROW_W-1:0] req_row,
  input  logic [COL_W-1:0] req_col,
  input  logic [LEN_W-1:0] req_len,
  input  logic [7:0]       dat_byte,
  output logic             dat_pop,
  output logic             busy,
  output logic             done,
  output logic             fail,
  output logic             timeout,
  output logic             spi_cs_n,
  output logic             spi_sclk,
  output logic             spi_mosi,
  input  logic             spi_miso
);
  localparam int PG_BITS = $clog2(PAGES_PER_BLK);
  localparam int PW      = $clog2(MAX_POLLS + 1);
  localparam int GAP     = 2 * CLK_DIV;
  localparam int CGW     = $clog2(GAP + 1);

  seq_st_e          st;
  logic             is_prog;
  logic [23:0]      row_q;
  logic [15:0]      col_q;
  logic [LEN_W-1:0] len_q;
  logic [PW-1:0]    polls;
  logic             to_q;
  logic             f_go, f_rd, f_done;
  logic [31:0]      f_hdr;
  logic [2:0]       f_hn;
  logic [LEN_W-1:0] f_tn;
  logic [7:0]       f_rx, stat;
  logic             t_go, t_exp;
  logic             fail_bit;

  snand_frame #(.CLK_DIV(CLK_DIV), .LEN_W(LEN_W)) u_frame (
    .clk(clk), .rst(rst), .start(f_go), .hdr(f_hdr), .hdr_n(f_hn),
    .tail_n(f_tn), .tail_rd(f_rd), .dat_byte(dat_byte), .dat_pop(dat_pop),
    .done(f_done), .rx_byte(f_rx), .cs_n(spi_cs_n), .sclk(spi_sclk),
    .mosi(spi_mosi), .miso(spi_miso)
  );

  snand_poll_timer #(.POLL_CYC(POLL_CYC)) u_timer (
    .clk(clk), .rst(rst), .start(t_go), .expire(t_exp)
  );

  assign stat     = f_rx & STAT_MASK;
  assign fail_bit = is_prog ? stat[ST_PFAIL] : stat[ST_EFAIL];

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= S_IDLE;
      busy    <= 1'b0;
      done    <= 1'b0;
      fail    <= 1'b0;
      timeout <= 1'b0;
      is_prog <= 1'b0;
      row_q   <= '0;
      col_q   <= '0;
      len_q   <= '0;
      polls   <= '0;
      to_q    <= 1'b0;
      f_go    <= 1'b0;
      f_rd    <= 1'b0;
      f_hdr   <= '0;
      f_hn    <= '0;
      f_tn    <= '0;
      t_go    <= 1'b0;
    end else begin
      done    <= 1'b0;
      fail    <= 1'b0;
      timeout <= 1'b0;
      f_go    <= 1'b0;
      t_go    <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          busy    <= 1'b1;
          is_prog <= req_prog;
          row_q   <= req_prog ? 24'(req_row) : (24'(req_block) << PG_BITS);
          col_q   <= 16'(req_col);
          len_q   <= req_len;
          polls   <= '0;
          f_go    <= 1'b1;
          f_hdr   <= {OP_WREN, 24'h0};
          f_hn    <= 3'd1;
          f_tn    <= '0;
          f_rd    <= 1'b0;
          st      <= S_WREN;
        end
        S_WREN: if (f_done) begin
          f_go <= 1'b1;
          f_rd <= 1'b0;
          if (is_prog) begin
            f_hdr <= {OP_LOAD, col_q, 8'h00};
            f_hn  <= 3'd3;
            f_tn  <= len_q;
            st    <= S_LOAD;
          end else begin
            f_hdr <= {OP_ERASE, row_q};
            f_hn  <= 3'd4;
            f_tn  <= '0;
            st    <= S_EXEC;
          end
        end
        S_LOAD: if (f_done) begin
          f_go  <= 1'b1;
          f_hdr <= {OP_EXEC, row_q};
          f_hn  <= 3'd4;
          f_tn  <= '0;
          st    <= S_EXEC;
        end
        S_EXEC: if (f_done) begin
          f_go  <= 1'b1;
          f_hdr <= {OP_GETF, FEAT_STATUS, 16'h0};
          f_hn  <= 3'd2;
          f_tn  <= LEN_W'(1);
          f_rd  <= 1'b1;
          st    <= S_POLL;
        end
        S_POLL: if (f_done) begin
          polls <= polls + PW'(1);
          if (!stat[ST_BUSY] && !fail_bit) begin
            done <= 1'b1;
            busy <= 1'b0;
            st   <= S_IDLE;
          end else if (!stat[ST_BUSY] || polls == PW'(MAX_POLLS - 1)) begin
            to_q  <= stat[ST_BUSY];
            f_go  <= 1'b1;
            f_hdr <= {OP_WRDI, 24'h0};
            f_hn  <= 3'd1;
            f_tn  <= '0;
            f_rd  <= 1'b0;
            st    <= S_WRDI;
          end else begin
            t_go <= 1'b1;
            st   <= S_WAIT;
          end
        end
        S_WAIT: if (t_exp) begin
          f_go <= 1'b1;
          st   <= S_POLL;
        end
        S_WRDI: if (f_done) begin
          busy    <= 1'b0;
          timeout <= to_q;
          fail    <= !to_q;
          st      <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  logic [CGW-1:0] cs_hi_cnt;
  always_ff @(posedge clk) begin
    if (rst) cs_hi_cnt <= CGW'(GAP);
    else if (!spi_cs_n) cs_hi_cnt <= '0;
    else if (cs_hi_cnt != CGW'(GAP)) cs_hi_cnt <= cs_hi_cnt + CGW'(1);
  end

  // R9
  flag_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({done, fail, timeout}));
  // R9
  busy_release_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (done || fail || timeout));
  // R9
  flag_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (done || fail || timeout) |-> !busy);
  // R11
  sclk_idle_chk: assert property (@(posedge clk) disable iff (rst)
    spi_cs_n |-> !spi_sclk);
  // R11
  cs_gap_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(spi_cs_n) |-> (cs_hi_cnt >= CGW'(GAP)));
  // R7
  timeout_count_chk: assert property (@(posedge clk) disable iff (rst)
    timeout |-> (polls == PW'(MAX_POLLS)));
endmodule

// File: tb/snand_pe_seq_tb_top.sv
module snand_pe_seq_tb_top;
  localparam int CLK_DIV = 2, POLL_CYC = 16, MAX_POLLS = 200;
  localparam int BLK_W = 10, ROW_W = 16, COL_W = 12, LEN_W = 12;
  localparam int GAP = 2 * CLK_DIV;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic             req_valid = 1'b0, req_prog = 1'b0;
  logic [BLK_W-1:0] req_block = '0;
  logic [ROW_W-1:0] req_row = '0;
  logic [COL_W-1:0] req_col = '0;
  logic [LEN_W-1:0] req_len = '0;
  logic [7:0]       dat_byte;
  logic dat_pop, busy, done, fail, timeout, spi_cs_n, spi_sclk, spi_mosi, spi_miso;

  int errors = 0, checks = 0;

  // device model state
  int op_id = 0, seen_id = 0;
  int busy_cfg = 0;
  logic [7:0] final_stat = 8'h00;
  logic [7:0] data_q [16];
  logic cs_q = 1'b1, sclk_q = 1'b0;
  int bitn = 0, nb = 0, hi_cnt = 0, last_gap = 0;
  int min_gap = 1000000, min_pgap = 1000000;
  bit prev_stat = 1'b0;
  int stat_frames = 0, bad_stat = 0, nlog = 0, didx = 0, pops = 0;
  logic [7:0] shreg = 8'h00;
  logic [7:0] cur [16];
  logic [7:0] log_b [8][16];
  int log_n [8];
  logic [7:0] cur_status;

  assign cur_status = (stat_frames < busy_cfg) ? 8'h01 : final_stat;
  assign spi_miso = (!spi_cs_n && bitn >= 16 && bitn < 24) ? cur_status[23 - bitn] : 1'b0;
  assign dat_byte = data_q[didx % 16];

  snand_pe_seq #(
    .CLK_DIV(CLK_DIV), .POLL_CYC(POLL_CYC), .MAX_POLLS(MAX_POLLS),
    .BLK_W(BLK_W), .ROW_W(ROW_W), .COL_W(COL_W), .LEN_W(LEN_W)
  ) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_prog(req_prog),
    .req_block(req_block), .req_row(req_row), .req_col(req_col),
    .req_len(req_len), .dat_byte(dat_byte), .dat_pop(dat_pop), .busy(busy),
    .done(done), .fail(fail), .timeout(timeout), .spi_cs_n(spi_cs_n),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  always @(negedge clk) begin
    logic [7:0] nsh;
    if (op_id != seen_id) begin
      seen_id = op_id; nlog = 0; stat_frames = 0; bad_stat = 0;
      prev_stat = 1'b0; didx = 0; pops = 0;
    end
    if (dat_pop) begin didx = didx + 1; pops = pops + 1; end
    if (cs_q && !spi_cs_n) begin
      bitn = 0; nb = 0; last_gap = hi_cnt;
      if (hi_cnt < min_gap) min_gap = hi_cnt;
    end
    if (spi_cs_n) hi_cnt = hi_cnt + 1; else hi_cnt = 0;
    if (!spi_cs_n && spi_sclk && !sclk_q) begin
      nsh = {shreg[6:0], spi_mosi};
      shreg = nsh;
      bitn = bitn + 1;
      if (bitn % 8 == 0) begin
        if (nb < 16) cur[nb] = nsh;
        nb = nb + 1;
      end
    end
    if (!cs_q && spi_cs_n) begin
      if (nb > 0 && cur[0] == 8'h0F) begin
        if (nb != 3 || cur[1] != 8'hC0) bad_stat = bad_stat + 1;
        if (prev_stat && last_gap < min_pgap) min_pgap = last_gap;
        prev_stat = 1'b1;
        stat_frames = stat_frames + 1;
      end else begin
        prev_stat = 1'b0;
        if (nlog < 8) begin
          log_n[nlog] = nb;
          for (int k = 0; k < 16; k++) log_b[nlog][k] = cur[k];
        end
        nlog = nlog + 1;
      end
    end
    cs_q = spi_cs_n;
    sclk_q = spi_sclk;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic chk_frame(input int idx, input string req, input logic [7:0] eb [16], input int en);
    int bad = -1;
    if (idx >= nlog || idx >= 8) begin
      chk(1'b0, req, nlog, idx + 1);
      return;
    end
    if (log_n[idx] != en) begin
      chk(1'b0, req, log_n[idx], en);
      return;
    end
    for (int k = 0; k < en && k < 16; k++)
      if (log_b[idx][k] !== eb[k]) begin bad = k; break; end
    if (bad >= 0) chk(1'b0, req, log_b[idx][bad], eb[bad]);
    else chk(1'b1, req, 0, 0);
  endtask

  task automatic run_op(input bit prog, input int blk, input int row, input int col,
                        input int len, input int nbusy, input logic [7:0] fst, input bit poke);
    logic [7:0] eb [16];
    int cyc, en, efr, row24, exp_stat, fi, snap;
    bit exp_to, exp_fail, busy_drop;
    logic [2:0] flagv, exp_flag;
    busy_cfg = nbusy;
    final_stat = fst;
    for (int i = 0; i < 16; i++) data_q[i] = 8'($urandom);
    op_id++;
    @(negedge clk);
    @(negedge clk);
    req_valid = 1'b1; req_prog = prog; req_block = BLK_W'(blk);
    req_row = ROW_W'(row); req_col = COL_W'(col); req_len = LEN_W'(len);
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy === 1'b1, "R9 busy after accept", busy, 1);
    cyc = 0; flagv = 3'b000; busy_drop = 1'b0;
    while (cyc < 60000) begin
      if (poke && cyc == 50) begin
        req_valid = 1'b1; req_prog = !prog; req_block = BLK_W'(blk ^ 3);
        req_row = ROW_W'(row ^ 16'h55); req_len = LEN_W'(2);
      end
      if (poke && cyc == 51) req_valid = 1'b0;
      @(negedge clk);
      cyc++;
      if (done || fail || timeout) begin flagv = {done, fail, timeout}; break; end
      if (!busy) busy_drop = 1'b1;
    end
    if (cyc >= 60000) begin
      chk(1'b0, "watchdog", cyc, 0);
      finish_run();
    end
    chk(busy === 1'b0 && !busy_drop, "R9 busy falls with flag", {busy_drop, busy}, 0);
    // expected outcome from the requirements
    exp_to   = (nbusy >= MAX_POLLS);
    exp_fail = !exp_to && (prog ? fst[3] : fst[2]);
    exp_flag = exp_to ? 3'b001 : (exp_fail ? 3'b010 : 3'b100);
    exp_stat = exp_to ? MAX_POLLS : nbusy + 1;
    if (exp_to) chk(flagv == exp_flag, "R7 timeout flag", flagv, exp_flag);
    else chk(flagv == exp_flag, "R6 done/fail flag", flagv, exp_flag);
    @(negedge clk);
    chk({done, fail, timeout} == 3'b000, "R9 single-cycle flag", {done, fail, timeout}, 0);
    // R1 write enable
    for (int k = 0; k < 16; k++) eb[k] = 8'h00;
    eb[0] = 8'h06;
    chk_frame(0, "R1 write enable frame", eb, 1);
    row24 = prog ? (row & 16'hFFFF) : ((blk & 10'h3FF) << 6);
    fi = 1;
    if (prog) begin
      eb[0] = 8'h84; eb[1] = 8'((col & 12'hFFF) >> 8); eb[2] = 8'(col);
      for (int k = 0; k < len; k++) eb[3 + k] = data_q[k];
      chk_frame(1, "R3 load frame", eb, 3 + len);
      chk(pops == len, "R3 dat_pop count", pops, len);
      eb[0] = 8'h10; eb[1] = 8'(row24 >> 16); eb[2] = 8'(row24 >> 8); eb[3] = 8'(row24);
      chk_frame(2, "R4 commit frame", eb, 4);
      fi = 3;
    end else begin
      eb[0] = 8'hD8; eb[1] = 8'(row24 >> 16); eb[2] = 8'(row24 >> 8); eb[3] = 8'(row24);
      chk_frame(1, "R2 erase frame", eb, 4);
      chk(pops == 0, "R2 no data pulled", pops, 0);
      fi = 2;
    end
    chk(stat_frames == exp_stat && bad_stat == 0, "R5 status frames", stat_frames, exp_stat);
    efr = (exp_to || exp_fail) ? fi + 1 : fi;
    chk(nlog == efr, "R8 frame count", nlog, efr);
    if (exp_to || exp_fail) begin
      eb[0] = 8'h04;
      chk_frame(fi, "R8 write disable frame", eb, 1);
    end
    if (poke) begin
      snap = nlog + stat_frames;
      repeat (200) @(negedge clk);
      chk(busy === 1'b0 && spi_cs_n === 1'b1 && (nlog + stat_frames) == snap,
          "R10 request while busy ignored", nlog + stat_frames, snap);
    end
  endtask

  initial begin
    #(200000 * 4);
    errors++; checks++;
    $display("FAIL watchdog actual=expired expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 16; i++) data_q[i] = 8'h00;
    repeat (4) @(negedge clk);
    chk(spi_cs_n === 1'b1 && spi_sclk === 1'b0 && busy === 1'b0 &&
        {done, fail, timeout, dat_pop} === 4'b0, "R12 reset state",
        {spi_cs_n, spi_sclk, busy, done, fail, timeout, dat_pop}, 7'b1000000);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    run_op(1'b0, 5, 0, 0, 0, 2, 8'h00, 1'b0);
    run_op(1'b0, 1023, 0, 0, 0, 0, 8'h08, 1'b0);   // R6 program bit on erase
    run_op(1'b0, 0, 0, 0, 0, 1, 8'h04, 1'b0);      // R6 erase fail
    run_op(1'b1, 0, 16'h1234, 12'h7FF, 5, 3, 8'h04, 1'b0); // R6 erase bit on program
    run_op(1'b1, 0, 16'hFFC0, 12'h000, 1, 0, 8'h08, 1'b0); // R6 program fail
    run_op(1'b1, 0, 16'h0A5A, 12'h123, 8, 2, 8'h00, 1'b1); // R10
    run_op(1'b0, 7, 0, 0, 0, MAX_POLLS - 1, 8'h00, 1'b0);  // R7 last poll succeeds
    run_op(1'b0, 9, 0, 0, 0, MAX_POLLS, 8'h00, 1'b0);      // R7 timeout
    for (int n = 0; n < 10; n++) begin
      run_op(1'($urandom), int'($urandom % 1024), int'($urandom % 65536),
             int'($urandom % 4096), 1 + int'($urandom % 8), int'($urandom % 7),
             8'($urandom) & 8'hFE, 1'b0);
    end
    chk(min_gap >= GAP, "R11 chip-select gap", min_gap, GAP);
    chk(min_pgap >= POLL_CYC, "R5 poll spacing", min_pgap, POLL_CYC);
    finish_run();
  end
endmodule